// File: doc/BRIEF.md
# Integer Multiply and Divide Execution Unit

This execution unit handles the eight multiply, divide and remainder operations of the 32-bit RISC-V M extension. It takes one operation at a time through a ready/valid handshake: a 4-bit operation code and two operands. It returns a single-cycle result strobe carrying the destination value, or a fault flag when the code is not one it implements.

Multiplication works on operand magnitudes. It forms the double-width unsigned product in one registered cycle and corrects the sign of the upper half afterwards. Division is iterative. It resolves two quotient bits per cycle, starting from the top bit, and it stops as soon as the partial remainder becomes zero. The operand signs are captured when the operation is accepted. A new operation is accepted only while the unit is idle.

Top module: `muldiv_unit`

## Requirements
- R1: During and right after reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Code 0000 returns the low XLEN bits of the product of `in_a` and `in_b`.
- R3: Code 0001 returns the upper XLEN bits of the product, with both operands treated as signed.
- R4: Code 0010 returns the upper XLEN bits of the product, with `in_a` signed and `in_b` unsigned.
- R5: Code 0011 returns the upper XLEN bits of the unsigned product.
- R6: A multiply accepted on a clock edge raises `out_valid`, with `out_fault` low, in the cycle right after that edge.
- R7: Code 0101 returns the unsigned quotient and code 0111 returns the unsigned remainder.
- R8: Code 0100 returns the signed quotient, rounded toward zero. Code 0110 returns the signed remainder, which carries the sign of the dividend.
- R9: When the divisor is zero, a quotient code returns all ones and a remainder code returns `in_a`.
- R10: The most negative value divided by -1 returns the dividend as the quotient and 0 as the remainder.
- R11: A divide returns its result in cycle 1 + k after acceptance. k is 0 when the dividend or divisor is zero. Otherwise k is the smallest j in 1..XLEN/2 for which the dividend magnitude is a multiple of the divisor magnitude times 2^(XLEN-2j); if there is none, k is XLEN/2.
- R12: Any code with bit 3 set produces a single result cycle, one cycle after acceptance, with `out_fault` high and `out_value` equal to 0.
- R13: `out_valid` lasts exactly one cycle. `in_ready` is low from acceptance through the result cycle and is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation accepted when `in_valid` is also high |
| in_op | input | 4 | Operation code |
| in_a | input | XLEN | First operand (multiplicand or dividend) |
| in_b | input | XLEN | Second operand (multiplier or divisor) |
| out_valid | output | 1 | Result strobe, one cycle |
| out_value | output | XLEN | Destination value |
| out_fault | output | 1 | Unsupported operation code |

## Verification
The bench builds the unit with XLEN = 4. At that width every pair of operands for every one of the eight codes can be swept, so the most negative value, -1, zero divisors and zero dividends all occur together with ordinary values. Each sweep point is also checked for its exact divide latency, which covers every early-exit depth of the two-bit-per-cycle loop. Codes 8 to 15 are swept against a selection of operands.

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_value,
  output logic            out_fault
);
  localparam int PW = $clog2(XLEN);
  localparam int W2 = 2 * XLEN;

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_DONE} state_t;

  state_t          st;
  logic [3:0]      op_q;
  logic [W2-1:0]   prod;
  logic [XLEN-1:0] rem, dvs, quo;
  logic [PW-1:0]   ptr;
  logic            neg_q, neg_r, dz;

  wire accept  = in_valid && in_ready;
  wire sa      = in_a[XLEN-1];
  wire sb      = in_b[XLEN-1];
  wire is_sdiv = (in_op == 4'b0100) || (in_op == 4'b0110);

  wire [XLEN-1:0] neg_a = -in_a;
  wire [XLEN-1:0] neg_b = -in_b;
  wire [XLEN-1:0] ma = (sa && (in_op == 4'b0001 || in_op == 4'b0010)) ? neg_a : in_a;
  wire [XLEN-1:0] mb = (sb && in_op == 4'b0001) ? neg_b : in_b;
  wire [XLEN-1:0] da = (sa && is_sdiv) ? neg_a : in_a;
  wire [XLEN-1:0] db = (sb && is_sdiv) ? neg_b : in_b;

  wire [W2-1:0]   nprod  = -prod;
  wire [XLEN-1:0] ptr_lo_pad = '0;
  wire [PW-1:0]   ptr_lo = ptr - 1'b1;

  logic [W2-1:0]   t_hi, t_lo;
  logic [XLEN-1:0] r_mid, nrem, nquo;

  always_comb begin
    t_hi  = {ptr_lo_pad, dvs} << ptr;
    t_lo  = {ptr_lo_pad, dvs} << ptr_lo;
    nquo  = quo;
    r_mid = rem;
    if ({ptr_lo_pad, rem} >= t_hi) begin
      r_mid     = rem - t_hi[XLEN-1:0];
      nquo[ptr] = 1'b1;
    end
    nrem = r_mid;
    if ({ptr_lo_pad, r_mid} >= t_lo) begin
      nrem         = r_mid - t_lo[XLEN-1:0];
      nquo[ptr_lo] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      prod  <= '0;
      rem   <= '0;
      dvs   <= '0;
      quo   <= '0;
      ptr   <= '0;
      neg_q <= 1'b0;
      neg_r <= 1'b0;
      dz    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q <= in_op;
          if (in_op[3]) begin
            st <= S_DONE;
          end else if (!in_op[2]) begin
            prod  <= {ptr_lo_pad, ma} * {ptr_lo_pad, mb};
            neg_q <= (in_op == 4'b0001) ? (sa ^ sb) : (in_op == 4'b0010) ? sa : 1'b0;
            st    <= S_MUL;
          end else begin
            rem   <= da;
            dvs   <= db;
            quo   <= '0;
            ptr   <= PW'(XLEN - 1);
            neg_q <= is_sdiv && (sa ^ sb);
            neg_r <= is_sdiv && sa;
            dz    <= (in_b == '0);
            st    <= (in_b == '0 || in_a == '0) ? S_DONE : S_DIV;
          end
        end
        S_DIV: begin
          rem <= nrem;
          quo <= nquo;
          ptr <= ptr - PW'(2);
          if (ptr == PW'(1) || nrem == '0) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready  = (st == S_IDLE);
  assign out_valid = (st == S_MUL) || (st == S_DONE);
  assign out_fault = (st == S_DONE) && op_q[3];

  always_comb begin
    out_value = '0;
    if (st == S_MUL) begin
      if (op_q[1:0] == 2'b00) out_value = prod[XLEN-1:0];
      else out_value = neg_q ? nprod[W2-1:XLEN] : prod[W2-1:XLEN];
    end else if (st == S_DONE && !op_q[3] && op_q[2]) begin
      if (op_q[1]) out_value = neg_r ? -rem : rem;
      else if (dz) out_value = '1;
      else out_value = neg_q ? -quo : quo;
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [3:0]      in_op,
  input logic [XLEN-1:0] in_a,
  input logic [XLEN-1:0] in_b,
  input logic            out_valid,
  input logic            out_fault
);
  wire acc = in_valid && in_ready;

  logic       div_busy;
  logic [7:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_busy <= 1'b0;
      div_cnt  <= '0;
    end else if (acc && in_op[3:2] == 2'b01) begin
      div_busy <= 1'b1;
      div_cnt  <= 8'd1;
    end else if (out_valid) begin
      div_busy <= 1'b0;
    end else if (div_busy) begin
      div_cnt <= div_cnt + 8'd1;
    end
  end

  // R6
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[3:2] == 2'b00) |=> (out_valid && !out_fault));

  // R12
  illegal_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[3]) |=> (out_valid && out_fault));

  // R12
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid);

  // R13
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R13
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R11
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (div_cnt <= 8'(XLEN / 2 + 1)));

  // R11
  div_zero_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[3:2] == 2'b01 && (in_a == '0 || in_b == '0)) |=> out_valid);
endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_fault(out_fault)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/1ps
module test_muldiv_unit;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [3:0]   in_op = '0;
  logic [N-1:0] in_a = '0, in_b = '0;
  logic         out_valid;
  logic [N-1:0] out_value;
  logic         out_fault;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  muldiv_unit #(.XLEN(N)) i_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_value(out_value), .out_fault(out_fault)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (op %0d a %0d b %0d)", req, act, exp, in_op, in_a, in_b);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= M / 2) ? v - M : v;
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic run_op(input int op, input int a, input int b);
    int lat, e, elat, ua, ub, sa, sb;
    longint p;
    string req;
    bit ready_low;
    @(negedge clk);
    check(in_ready == 1'b1, "R13", in_ready, 1);
    in_op = 4'(op); in_a = N'(a); in_b = N'(b); in_valid = 1'b1;
    lat = 0;
    ready_low = 1'b1;
    do begin
      @(negedge clk);
      in_valid = 1'b0;
      lat++;
      if (in_ready) ready_low = 1'b0;
    end while (!out_valid && lat < 40);
    check(ready_low, "R13", 0, 0);
    sa = sx(a); sb = sx(b);
    e = 0; elat = 1; req = "R12";
    case (op)
      0: begin req = "R2"; e = (a * b) % M; end
      1: begin req = "R3"; p = longint'(sa) * longint'(sb); e = int'((p >>> N) & (M - 1)); end
      2: begin req = "R4"; p = longint'(sa) * longint'(b);  e = int'((p >>> N) & (M - 1)); end
      3: begin req = "R5"; e = (a * b) >> N; end
      4: begin
        req = "R8";
        if (b == 0) begin req = "R9"; e = M - 1; end
        else if (sa == -M / 2 && sb == -1) begin req = "R10"; e = a; end
        else e = (sa / sb) & (M - 1);
      end
      5: begin req = "R7"; e = (b == 0) ? M - 1 : a / b; if (b == 0) req = "R9"; end
      6: begin
        req = "R8";
        if (b == 0) begin req = "R9"; e = a; end
        else if (sa == -M / 2 && sb == -1) begin req = "R10"; e = 0; end
        else e = (sa % sb) & (M - 1);
      end
      7: begin req = "R7"; e = (b == 0) ? a : a % b; if (b == 0) req = "R9"; end
      default: e = 0;
    endcase
    if (op >= 4 && op <= 7) begin
      ua = (op == 4 || op == 6) ? absv(sa) : a;
      ub = (op == 4 || op == 6) ? absv(sb) : b;
      if (ua == 0 || ub == 0) elat = 1;
      else begin
        elat = 1 + N / 2;
        for (int j = N / 2; j >= 1; j--)
          if ((ua % (ub << (N - 2 * j))) == 0) elat = 1 + j;
      end
      check(lat == elat, "R11", lat, elat);
    end else if (op < 4) begin
      check(lat == 1, "R6", lat, 1);
    end else begin
      check(lat == 1, "R12", lat, 1);
    end
    check(out_valid == 1'b1, req, out_valid, 1);
    check(int'(out_value) == e, req, int'(out_value), e);
    check(out_fault == (op >= 8), (op >= 8) ? "R12" : req, out_fault, int'(op >= 8));
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R13", {out_valid, in_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 2);
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++)
          run_op(op, a, b);
    for (int op = 8; op < 16; op++)
      for (int a = 0; a < M; a += 5)
        run_op(op, a, M - 1 - a);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule